// File: doc/BRIEF.md
# Block Floating Point Formatter

This block takes a block of N signed samples, each a two's-complement mantissa carrying its own small exponent, and rewrites the whole block under one shared exponent. For every sample it counts how many fraction bits just below the sign repeat the sign. The sample exponent minus that count is the exponent the sample would carry if it were normalised. The block exponent is the largest of these values plus a scaling margin S, so each mantissa keeps headroom for a later sum of products. To feed plain fixed-point data, tie every sample exponent to zero.

Samples enter one per cycle through a valid/ready handshake. During this loading pass the block stores each sample and tracks the running maximum of the normalised exponents. A second pass then sends out the aligned mantissas, one per cycle, in the order they arrived. The shared exponent is shown on its own port for the whole second pass, and a one-cycle done strobe marks the last mantissa. The margin S is taken with the first sample of each block.

Top module: `bfp_formatter`

## Requirements
- R1: `out_exp` equals max over the block of (e_l − n_l) + S, where e_l is the signed sample exponent, n_l is the count of fraction bits (from bit MW−2 downward) equal to the sign bit, and S is the margin. The value is read as a signed XW-bit number.
- R2: A negative mantissa whose fraction bits below its sign run are all zero uses n_l − 1. This makes the full-scale negative code 0x800 count as n_l = −1, and 0xC00 (−0.5) count as 0.
- R3: When every e_l is zero, `out_exp` equals S minus the smallest n_l in the block.
- R4: With d = out_exp − e_l ≥ 0, the output mantissa is the input mantissa arithmetically shifted right by d, with the dropped bits truncated (rounded toward minus infinity). Once d reaches the mantissa width, the result is all sign bits.
- R5: With d < 0, the output mantissa is the input shifted left by −d, and the value is exact.
- R6: Output mantissas come out in arrival order on N consecutive cycles with `out_valid` high. The first one is registered on the clock edge after the edge that accepts the N-th sample.
- R7: `out_done` is high for exactly one cycle, together with the N-th output mantissa, and at no other time.
- R8: Every output mantissa m satisfies −2^(MW−1−S) ≤ m < 2^(MW−1−S).
- R9: `in_ready` is low from the edge that accepts the N-th sample until the last mantissa is presented. Samples offered while it is low are dropped and do not appear in any later block.
- R10: S is captured with the first sample of a block. Changes on `in_scale` later in that block have no effect.
- R11: `out_exp` holds steady across all cycles of one output pass.
- R12: After reset, `out_valid` and `out_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_mant | input | MW | Signed sample mantissa, one sign bit and MW−1 fraction bits |
| in_exp | input | EW | Signed sample exponent |
| in_scale | input | SW | Margin S, unsigned, taken with the first sample |
| out_valid | output | 1 | Aligned mantissa present |
| out_mant | output | MW | Aligned signed mantissa |
| out_exp | output | XW | Signed shared block exponent |
| out_done | output | 1 | Marks the last mantissa of the block |

## Verification
A wrong running maximum shows up at once in `out_exp` and in every mantissa of the next pass. The exponent is then off by a constant for the whole block, and each mantissa is shifted by the wrong amount. A wrong sign-run count, or a missing power-of-two correction, only changes the result when the affected sample sets the maximum. For that reason the bench uses blocks in which the extreme sample is a negative power of two, zero, or full scale. Errors in the counter or the storage show up as outputs out of order, a gap in `out_valid`, or `out_done` on the wrong cycle. All of these appear within the N cycles of the output pass that follows.

// File: rtl/bfp_formatter.sv
module bfp_formatter #(
  parameter int N  = 20,
  parameter int MW = 12,
  parameter int EW = 4,
  parameter int SW = 3,
  parameter int XW = EW + $clog2(MW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [MW-1:0] in_mant,
  input  logic [EW-1:0] in_exp,
  input  logic [SW-1:0] in_scale,
  output logic          out_valid,
  output logic [MW-1:0] out_mant,
  output logic [XW-1:0] out_exp,
  output logic          out_done
);
  localparam int CW = $clog2(N);
  localparam int FW = MW - 1;

  function automatic logic [XW-1:0] ext_exp(input logic [EW-1:0] e);
    return {{(XW-EW){e[EW-1]}}, e};
  endfunction

  function automatic logic [XW-1:0] norm_key(input logic [MW-1:0] m, input logic [EW-1:0] e);
    logic          sg;
    logic          run;
    logic [FW-1:0] rest;
    int            n;
    sg  = m[MW-1];
    run = 1'b1;
    n   = 0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (run && m[i] == sg) n++;
      else run = 1'b0;
    end
    rest = m[FW-1:0] << n;
    if (sg && rest == '0) n--;
    return ext_exp(e) - XW'(n);
  endfunction

  function automatic logic [MW-1:0] align(input logic [MW-1:0] m, input logic [XW-1:0] d);
    logic [XW-1:0] amt;
    logic [MW-1:0] r;
    if (!d[XW-1]) begin
      amt = d;
      r   = $signed(m) >>> amt;
    end else begin
      amt = -d;
      r   = m << amt;
    end
    return r;
  endfunction

  logic [MW+EW-1:0] store [N];
  logic             emit_q;
  logic [CW-1:0]    cnt_q;
  logic [XW-1:0]    emax_q;
  logic [SW-1:0]    scale_q;

  logic [XW-1:0]    key;
  logic [XW-1:0]    nmax;
  logic [SW-1:0]    scale_eff;
  logic [MW+EW-1:0] rd;
  logic             last;

  assign in_ready  = !emit_q;
  assign key       = norm_key(in_mant, in_exp);
  assign nmax      = (cnt_q == '0 || $signed(key) > $signed(emax_q)) ? key : emax_q;
  assign scale_eff = (cnt_q == '0) ? in_scale : scale_q;
  assign rd        = store[cnt_q];
  assign last      = cnt_q == CW'(N - 1);

  always_ff @(posedge clk)
    if (!emit_q && in_valid) store[cnt_q] <= {in_exp, in_mant};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_q    <= 1'b0;
      cnt_q     <= '0;
      emax_q    <= '0;
      scale_q   <= '0;
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      out_mant  <= '0;
      out_exp   <= '0;
    end else begin
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      if (!emit_q) begin
        if (in_valid) begin
          emax_q  <= nmax;
          scale_q <= scale_eff;
          if (last) begin
            emit_q  <= 1'b1;
            cnt_q   <= '0;
            out_exp <= nmax + {{(XW-SW){1'b0}}, scale_eff};
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else begin
        out_valid <= 1'b1;
        out_mant  <= align(rd[MW-1:0], out_exp - ext_exp(rd[MW+EW-1:MW]));
        out_done  <= last;
        if (last) begin
          emit_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bfp_formatter_chk.sv
module bfp_formatter_chk #(
  parameter int N  = 20,
  parameter int MW = 12,
  parameter int SW = 3,
  parameter int XW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_done,
  input logic [MW-1:0] out_mant,
  input logic [XW-1:0] out_exp,
  input logic [SW-1:0] scale_q
);
  int ocnt;
  int lim;
  assign lim = 1 << (MW - 1 - int'(scale_q));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ocnt <= 0;
    else if (out_valid) ocnt <= out_done ? 0 : ocnt + 1;

  assert_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_valid && ocnt == N - 1));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);
  assert_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_done) |=> out_valid);
  assert_headroom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'($signed(out_mant)) < lim && int'($signed(out_mant)) >= -lim));
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_done) |-> !in_ready);
  assert_exp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_done) |=> $stable(out_exp));
endmodule

bind bfp_formatter bfp_formatter_chk #(.N(N), .MW(MW), .SW(SW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_done(out_done), .out_mant(out_mant), .out_exp(out_exp), .scale_q(scale_q)
);

// File: tb/tb_bfp_formatter.sv
`timescale 1ns/1ps
module tb_bfp_formatter;
  localparam int N = 20, MW = 12, EW = 4, SW = 3;
  localparam int XW = EW + $clog2(MW) + 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [MW-1:0] in_mant = '0;
  logic [EW-1:0] in_exp = '0;
  logic [SW-1:0] in_scale = '0;
  logic out_valid, out_done;
  logic [MW-1:0] out_mant;
  logic [XW-1:0] out_exp;

  always #2 clk = ~clk;

  bfp_formatter #(.N(N), .MW(MW), .EW(EW), .SW(SW)) dut (.*);

  int n_chk = 0, n_bad = 0;
  int q_m[$], q_e[$];
  bit q_l[$];
  string q_t[$];
  bit finished = 0;

  function automatic int sign_run(int m);
    for (int k = MW - 1; k >= 0; k--)
      if (m * (1 << k) > -(1 << (MW - 1)) && m * (1 << k) < (1 << (MW - 1))) return k;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send_block(int mode, int s, string tag, bit gaps, bit junk);
    int mv[N], ev[N];
    int emax, bexp, d, r;
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: begin mv[i] = (i % 5 - 2) * (i + 3); ev[i] = 0; end
        1: begin mv[i] = (i * 373) % 2048 - 1024; ev[i] = i % 7 - 3; end
        2: begin mv[i] = -(1 << (i % 12)); ev[i] = i % 3 - 1; end
        3: begin mv[i] = (i == 7) ? -1 : 0; ev[i] = i % 16 - 8; end
        4: begin mv[i] = (i % 2 == 1) ? 2047 : -(i * 50 + 1); ev[i] = (i % 2 == 1) ? 7 : -8; end
        default: begin mv[i] = 600 - i * 57; ev[i] = i % 4 - 2; end
      endcase
    end
    emax = ev[0] - sign_run(mv[0]);
    for (int i = 1; i < N; i++)
      if (ev[i] - sign_run(mv[i]) > emax) emax = ev[i] - sign_run(mv[i]);
    bexp = emax + s;
    for (int i = 0; i < N; i++) begin
      d = bexp - ev[i];
      if (d >= 0) r = (d > 30) ? ((mv[i] < 0) ? -1 : 0) : (mv[i] >>> d);
      else r = mv[i] * (1 << (-d));
      q_m.push_back(r); q_e.push_back(bexp); q_l.push_back(i == N - 1); q_t.push_back(tag);
    end
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (gaps && i % 3 == 1) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_mant = MW'(mv[i]);
      in_exp = EW'(ev[i]);
      in_scale = (i > 0 && mode == 5) ? SW'(7 - s) : SW'(s);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    if (junk) begin
      for (int j = 0; j < N - 4; j++) begin
        in_valid = 1; in_mant = MW'(12'h5A5); in_exp = EW'(7); in_scale = '0;
        @(negedge clk);
      end
    end
    in_valid = 0;
  endtask

  initial begin : monitor
    bit run = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (run && !out_valid) check(0, "R6 gap in output pass", 0, 1);
        if (out_done && !out_valid) check(0, "R7 done without valid", 0, 1);
        if (out_valid) begin
          if (q_m.size() == 0) check(0, "R6 unexpected output", int'($signed(out_mant)), 0);
          else begin
            int em, ee; bit el; string et;
            em = q_m.pop_front(); ee = q_e.pop_front(); el = q_l.pop_front(); et = q_t.pop_front();
            check(int'($signed(out_mant)) == em, {"R4/R5/R6 mantissa ", et}, int'($signed(out_mant)), em);
            check(int'($signed(out_exp)) == ee, {"R1/R11 exponent ", et}, int'($signed(out_exp)), ee);
            check(out_done == el, {"R7 done ", et}, int'(out_done), int'(el));
            if (!out_done) check(!in_ready, {"R9 ready during pass ", et}, int'(in_ready), 0);
          end
          run = !out_done;
        end else run = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(!out_valid && !out_done && in_ready, "R12 reset state", int'({out_valid, out_done, in_ready}), 1);
    rst_n = 1;
    send_block(0, 2, "R3 fixed-point", 0, 1);
    send_block(1, 1, "R1 mixed exponents", 1, 0);
    send_block(2, 0, "R2 negative powers of two", 0, 0);
    send_block(3, 4, "R8 mostly zero", 0, 1);
    send_block(4, 7, "R4 extreme shifts", 0, 0);
    send_block(5, 3, "R10 scale from first sample", 1, 0);
    send_block(0, 0, "R5 fixed-point no margin", 0, 0);
    repeat (N + 6) @(negedge clk);
    check(q_m.size() == 0, "R6 outputs missing", q_m.size(), 0);
    check(!out_valid && in_ready, "R9 idle after pass", int'({out_valid, in_ready}), 1);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule